// File: doc/BRIEF.md
# Dual Limiter Gain Controller

This block runs two independent level limiters and turns their state into a gain-reduction value for each audio channel. Every channel carries a 2-bit routing code that ties it to limiter A, limiter B or to neither. On each sample strobe a limiter looks at the largest limited magnitude among its channels. If that peak is above the attack level, the gain reduction grows by the attack step. If the peak is not above the attack level and a smoothed mean-square estimate of the limited peak is below the square of the release level, the reduction shrinks by the release step. In every other case it holds.

A single mode input picks the reference for all four level selectors. In anti-clip mode a selector names an absolute level. In compression mode the same level is scaled by the current volume, so the limiting follows the listening level. The downstream datapath applies the gain-reduction outputs. A channel that is not routed to a limiter always reads zero.

Top module: `dual_limiter_ctrl`

## Requirements
- R1: While reset is active, and after it is released until the first sample strobe, every gain-reduction output is 0.
- R2: Channel routing code 2'b01 selects limiter A and 2'b10 selects limiter B. Codes 2'b00 and 2'b11 give a gain-reduction output of 0 on that channel.
- R3: The two limiters keep separate state. Stimulus on channels routed to one limiter never changes the other limiter's gain reduction.
- R4: Attack. On a strobe where the limiter's peak is greater than its attack level, its gain reduction rises by (attack rate select + 1) and saturates at GR_MAX (192 by default).
- R5: Release. On a strobe with no attack where the mean-square estimate is below the release level squared, the gain reduction falls by (release rate select + 1) and stops at 0. Attack takes precedence when both conditions hold.
- R6: Gain reduction holds on a strobe that meets neither condition. It also holds in every cycle without a strobe, whatever the inputs do.
- R7: In anti-clip mode (mode input 0) a 4-bit level select s gives the level (s+1)·2^(MAG_W-4).
- R8: In compression mode (mode input 1) the level is ((s+1)·2^(MAG_W-4)·(vol+1)) >> VOL_W.
- R9: A channel's limited magnitude is (mag·(2^GR_W − gr)) >> GR_W, where gr is the limiter's current reduction. The peak is the maximum over the limiter's channels. On each strobe the mean-square estimate ms moves toward peak² by |peak² − ms| >> RMS_SHIFT, using the value of gr from before that strobe.
- R10: A limiter with no channel routed to it sees a peak of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per frame |
| mag_in | input | NUM_CH*MAG_W | Per-channel sample magnitudes, channel 0 in the low bits |
| vol_lvl | input | VOL_W | Volume setting, used in compression mode |
| drc_mode | input | 1 | 0 selects anti-clip levels, 1 selects volume-relative levels |
| ch_map | input | 2*NUM_CH | Per-channel 2-bit limiter routing code |
| atk_thr_sel | input | 8 | Attack level select, limiter A in [3:0] and B in [7:4] |
| rel_thr_sel | input | 8 | Release level select, same packing |
| atk_rate_sel | input | 8 | Attack step select, same packing |
| rel_rate_sel | input | 8 | Release step select, same packing |
| gr_out | output | NUM_CH*GR_W | Per-channel gain reduction, channel 0 in the low bits |

## Verification
Attack and release can both be true on the same strobe. The peak is above the attack level while the mean-square estimate is still below the release level. This always happens on the first loud strobe after reset, because the estimate starts at zero, and the random run with a generous release selector produces it many more times. The bench judges the outcome by whether the reduction rose by the attack step, which shows that attack won. It compares every strobe against a cycle model that applies attack first, so a swapped priority shows up as a downward step where an upward one was expected.

// File: rtl/dlim_pkg.sv
package dlim_pkg;
   localparam int SEL_W   = 4;
   localparam int NUM_LIM = 2;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'b00,
      ROUTE_A    = 2'b01,
      ROUTE_B    = 2'b10,
      ROUTE_OFF  = 2'b11
   } route_e;
endpackage

// File: rtl/dlim_thresh.sv
// Turns a 4-bit level selector into a magnitude level, either absolute
// or scaled by the volume setting.
module dlim_thresh #(
   parameter int MAG_W = 16,
   parameter int VOL_W = 8,
   parameter int LVL_W = MAG_W + 1
) (
   input  logic [dlim_pkg::SEL_W-1:0] sel,
   input  logic [VOL_W-1:0]           vol,
   input  logic                       drc,
   output logic [LVL_W-1:0]           lvl
);
   localparam int PROD_W = LVL_W + VOL_W + 1;
   localparam int STEP_SH = MAG_W - dlim_pkg::SEL_W;

   logic [LVL_W-1:0]  base_lvl;
   logic [PROD_W-1:0] rel_prod;

   assign base_lvl = LVL_W'({1'b0, sel} + 5'd1) << STEP_SH;          // R7
   assign rel_prod = PROD_W'(base_lvl) * (PROD_W'(vol) + PROD_W'(1)); // R8
   assign lvl      = drc ? LVL_W'(rel_prod >> VOL_W) : base_lvl;
endmodule

// File: rtl/dlim_level.sv
// Per-limiter level detector: limited peak over routed channels and a
// leaky mean-square estimate of that peak.
module dlim_level #(
   parameter int          NUM_CH    = 3,
   parameter int          MAG_W     = 16,
   parameter int          GR_W      = 8,
   parameter int          RMS_SHIFT = 2,
   parameter logic [1:0]  LIM_CODE  = 2'b01
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_vld,
   input  logic [NUM_CH*MAG_W-1:0] mag_in,
   input  logic [2*NUM_CH-1:0]    ch_map,
   input  logic [GR_W-1:0]        gr,
   output logic [MAG_W-1:0]       peak,
   output logic [2*MAG_W-1:0]     ms
);
   localparam int SCL_W  = GR_W + 1;
   localparam int PROD_W = MAG_W + SCL_W;
   localparam int SQ_W   = 2 * MAG_W;

   logic [SCL_W-1:0] scale;
   logic [MAG_W-1:0] lim_mag [NUM_CH];
   logic [SQ_W-1:0]  sq;
   logic [SQ_W-1:0]  ms_nxt;

   assign scale = {1'b1, {GR_W{1'b0}}} - {1'b0, gr};

   // R9: limited magnitude per channel, zero when not routed here (R10)
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [PROD_W-1:0] prod;
      assign prod       = PROD_W'(mag_in[c*MAG_W +: MAG_W]) * PROD_W'(scale);
      assign lim_mag[c] = (ch_map[c*2 +: 2] == LIM_CODE) ? MAG_W'(prod >> GR_W) : '0;
   end

   always_comb begin
      peak = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (lim_mag[c] > peak) peak = lim_mag[c];
      end
   end

   assign sq = SQ_W'(peak) * SQ_W'(peak);

   if (RMS_SHIFT == 0) begin : g_raw
      assign ms_nxt = sq;
   end else begin : g_leaky
      always_comb begin
         if (sq >= ms) ms_nxt = ms + ((sq - ms) >> RMS_SHIFT);
         else          ms_nxt = ms - ((ms - sq) >> RMS_SHIFT);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ms <= '0;
      else if (smp_vld) ms <= ms_nxt;
   end

   AST_MS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(ms)); // R9
   AST_MS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && sq >= ms) |=> ms >= $past(ms)); // R9
   AST_MS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && sq < ms) |=> ms <= $past(ms)); // R9
endmodule

// File: rtl/dlim_gain.sv
// Gain-reduction state of one limiter: attack, release or hold.
module dlim_gain #(
   parameter int MAG_W  = 16,
   parameter int LVL_W  = MAG_W + 1,
   parameter int GR_W   = 8,
   parameter int GR_MAX = 192
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_vld,
   input  logic [MAG_W-1:0]           peak,
   input  logic [2*MAG_W-1:0]         ms,
   input  logic [LVL_W-1:0]           atk_lvl,
   input  logic [LVL_W-1:0]           rel_lvl,
   input  logic [dlim_pkg::SEL_W-1:0] atk_rate,
   input  logic [dlim_pkg::SEL_W-1:0] rel_rate,
   output logic [GR_W-1:0]            gr
);
   localparam int RSQ_W = 2 * LVL_W;
   localparam int EXT_W = GR_W + 1;
   localparam logic [EXT_W-1:0] CEIL = EXT_W'(GR_MAX);

   logic             atk_hit;
   logic             rel_hit;
   logic [RSQ_W-1:0] rel_sq;
   logic [EXT_W-1:0] atk_step;
   logic [EXT_W-1:0] rel_step;
   logic [EXT_W-1:0] up_sum;
   logic [GR_W-1:0]  gr_up;
   logic [GR_W-1:0]  gr_dn;
   logic [GR_W-1:0]  gr_nxt;

   assign atk_hit  = LVL_W'(peak) > atk_lvl;
   assign rel_sq   = RSQ_W'(rel_lvl) * RSQ_W'(rel_lvl);
   assign rel_hit  = RSQ_W'(ms) < rel_sq;
   assign atk_step = EXT_W'(atk_rate) + EXT_W'(1);
   assign rel_step = EXT_W'(rel_rate) + EXT_W'(1);
   assign up_sum   = {1'b0, gr} + atk_step;
   assign gr_up    = (up_sum > CEIL) ? CEIL[GR_W-1:0] : up_sum[GR_W-1:0];
   assign gr_dn    = ({1'b0, gr} > rel_step) ? (gr - rel_step[GR_W-1:0]) : '0;

   always_comb begin
      gr_nxt = gr;
      if (atk_hit)      gr_nxt = gr_up;   // R4, attack first
      else if (rel_hit) gr_nxt = gr_dn;   // R5
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gr <= '0;
      else if (smp_vld) gr <= gr_nxt;
   end

   AST_GR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      gr <= CEIL[GR_W-1:0]); // R4
   AST_ATK_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && atk_hit && {1'b0, gr} < CEIL) |=> gr > $past(gr)); // R4
   AST_REL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !atk_hit && rel_hit && gr != '0) |=> gr < $past(gr)); // R5
   AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !atk_hit && !rel_hit) |=> $stable(gr)); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(gr)); // R6
endmodule

// File: rtl/dual_limiter_ctrl.sv
module dual_limiter_ctrl #(
   parameter int NUM_CH    = 3,
   parameter int MAG_W     = 16,
   parameter int VOL_W     = 8,
   parameter int GR_W      = 8,
   parameter int GR_MAX    = 192,
   parameter int RMS_SHIFT = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_vld,
   input  logic [NUM_CH*MAG_W-1:0] mag_in,
   input  logic [VOL_W-1:0]        vol_lvl,
   input  logic                    drc_mode,
   input  logic [2*NUM_CH-1:0]     ch_map,
   input  logic [7:0]              atk_thr_sel,
   input  logic [7:0]              rel_thr_sel,
   input  logic [7:0]              atk_rate_sel,
   input  logic [7:0]              rel_rate_sel,
   output logic [NUM_CH*GR_W-1:0]  gr_out
);
   import dlim_pkg::*;

   localparam int LVL_W = MAG_W + 1;

   if (GR_W < 5 || GR_MAX < 1 || GR_MAX >= (1 << GR_W)) begin : g_bad_gr
      $error("dual_limiter_ctrl: GR_W/GR_MAX out of range");
   end
   if (MAG_W <= SEL_W || NUM_CH < 1) begin : g_bad_mag
      $error("dual_limiter_ctrl: MAG_W or NUM_CH out of range");
   end
   if (RMS_SHIFT < 0 || RMS_SHIFT >= 2 * MAG_W) begin : g_bad_rms
      $error("dual_limiter_ctrl: RMS_SHIFT out of range");
   end

   logic [GR_W-1:0] lim_gr [NUM_LIM];

   for (genvar l = 0; l < NUM_LIM; l++) begin : g_lim
      logic [LVL_W-1:0]   atk_lvl;
      logic [LVL_W-1:0]   rel_lvl;
      logic [MAG_W-1:0]   peak;
      logic [2*MAG_W-1:0] ms;
      logic [GR_W-1:0]    gr;

      dlim_thresh #(.MAG_W(MAG_W), .VOL_W(VOL_W), .LVL_W(LVL_W)) u_atk_thr (
         .sel (atk_thr_sel[l*SEL_W +: SEL_W]),
         .vol (vol_lvl),
         .drc (drc_mode),
         .lvl (atk_lvl)
      );

      dlim_thresh #(.MAG_W(MAG_W), .VOL_W(VOL_W), .LVL_W(LVL_W)) u_rel_thr (
         .sel (rel_thr_sel[l*SEL_W +: SEL_W]),
         .vol (vol_lvl),
         .drc (drc_mode),
         .lvl (rel_lvl)
      );

      dlim_level #(
         .NUM_CH   (NUM_CH),
         .MAG_W    (MAG_W),
         .GR_W     (GR_W),
         .RMS_SHIFT(RMS_SHIFT),
         .LIM_CODE (2'(l + 1))
      ) u_level (
         .clk    (clk),
         .rst_n  (rst_n),
         .smp_vld(smp_vld),
         .mag_in (mag_in),
         .ch_map (ch_map),
         .gr     (gr),
         .peak   (peak),
         .ms     (ms)
      );

      dlim_gain #(
         .MAG_W (MAG_W),
         .LVL_W (LVL_W),
         .GR_W  (GR_W),
         .GR_MAX(GR_MAX)
      ) u_gain (
         .clk     (clk),
         .rst_n   (rst_n),
         .smp_vld (smp_vld),
         .peak    (peak),
         .ms      (ms),
         .atk_lvl (atk_lvl),
         .rel_lvl (rel_lvl),
         .atk_rate(atk_rate_sel[l*SEL_W +: SEL_W]),
         .rel_rate(rel_rate_sel[l*SEL_W +: SEL_W]),
         .gr      (gr)
      );

      assign lim_gr[l] = gr;
   end

   // R2: per-channel routing of limiter state to the outputs
   for (genvar c = 0; c < NUM_CH; c++) begin : g_out
      route_e route;
      assign route = route_e'(ch_map[c*2 +: 2]);

      always_comb begin
         unique case (route)
            ROUTE_A: gr_out[c*GR_W +: GR_W] = lim_gr[0];
            ROUTE_B: gr_out[c*GR_W +: GR_W] = lim_gr[1];
            default: gr_out[c*GR_W +: GR_W] = '0;
         endcase
      end

      AST_UNROUTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (gr_out[c*GR_W +: GR_W] != '0) |-> (route == ROUTE_A || route == ROUTE_B)); // R2
   end

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |-> gr_out == '0); // R1
endmodule

// File: tb/dual_limiter_ctrl_bench.sv
module dual_limiter_ctrl_bench;
   localparam int NCH  = 3;
   localparam int MW   = 16;
   localparam int GW   = 8;
   localparam int GMAX = 192;
   localparam int K    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic [NCH*MW-1:0] mag_in = '0;
   logic [7:0] vol_lvl = '0;
   logic drc_mode = 1'b0;
   logic [2*NCH-1:0] ch_map = '0;
   logic [7:0] atk_thr_sel = '0, rel_thr_sel = '0, atk_rate_sel = '0, rel_rate_sel = '0;
   logic [NCH*GW-1:0] gr_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   longint m_gr [2];
   longint m_ms [2];

   always #5 clk = ~clk;

   dual_limiter_ctrl u_dual_limiter_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mag_in(mag_in),
      .vol_lvl(vol_lvl), .drc_mode(drc_mode), .ch_map(ch_map),
      .atk_thr_sel(atk_thr_sel), .rel_thr_sel(rel_thr_sel),
      .atk_rate_sel(atk_rate_sel), .rel_rate_sel(rel_rate_sel),
      .gr_out(gr_out));

   function automatic longint level_of(int sel, int vol, bit drc);
      longint b = longint'(sel + 1) << (MW - 4);
      return drc ? ((b * (vol + 1)) >> 8) : b;
   endfunction

   function automatic longint exp_out(int c);
      int code = int'(ch_map[c*2 +: 2]);
      if (code == 1) return m_gr[0];
      if (code == 2) return m_gr[1];
      return 0;
   endfunction

   task automatic model_step();
      longint pk [2];
      for (int l = 0; l < 2; l++) begin
         pk[l] = 0;
         for (int c = 0; c < NCH; c++) begin
            if (int'(ch_map[c*2 +: 2]) == l + 1) begin
               longint lm = (longint'(mag_in[c*MW +: MW]) * (256 - m_gr[l])) >> 8;
               if (lm > pk[l]) pk[l] = lm;
            end
         end
      end
      for (int l = 0; l < 2; l++) begin
         longint a  = level_of(int'(atk_thr_sel[l*4 +: 4]), int'(vol_lvl), drc_mode);
         longint r  = level_of(int'(rel_thr_sel[l*4 +: 4]), int'(vol_lvl), drc_mode);
         longint as = longint'(atk_rate_sel[l*4 +: 4]) + 1;
         longint rs = longint'(rel_rate_sel[l*4 +: 4]) + 1;
         longint sq = pk[l] * pk[l];
         if (pk[l] > a)              m_gr[l] = (m_gr[l] + as > GMAX) ? GMAX : m_gr[l] + as;
         else if (m_ms[l] < r * r)   m_gr[l] = (m_gr[l] > rs) ? m_gr[l] - rs : 0;
         if (sq >= m_ms[l]) m_ms[l] = m_ms[l] + ((sq - m_ms[l]) >> K);
         else               m_ms[l] = m_ms[l] - ((m_ms[l] - sq) >> K);
      end
   endtask

   task automatic check_all(string tag);
      for (int c = 0; c < NCH; c++) begin
         longint got = longint'(gr_out[c*GW +: GW]);
         longint ex  = exp_out(c);
         checks++;
         if (got != ex) begin
            errors++;
            $display("FAIL %s ch%0d got %0d expected %0d", tag, c, got, ex);
         end
      end
   endtask

   task automatic strobe(string tag);
      smp_vld = 1'b1;
      @(posedge clk);
      model_step();
      @(negedge clk);
      smp_vld = 1'b0;
      check_all(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      m_gr[0] = 0; m_gr[1] = 0; m_ms[0] = 0; m_ms[1] = 0;
      // R1: outputs during and right after reset
      ch_map = 6'b10_01_01;
      mag_in = {3{16'hFFFF}};
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");

      // R2: codes 00 and 11 read zero even with loud input
      ch_map = 6'b11_00_11;
      atk_thr_sel = 8'h00; atk_rate_sel = 8'hFF;
      strobe("R2 unrouted");
      // R10: no channel routed, peaks are 0, so nothing attacks
      strobe("R10 empty limiter");

      // R4/R7: ch0 on A, absolute level 4096, step 4
      ch_map = 6'b11_00_01;
      atk_rate_sel = 8'h33; rel_thr_sel = 8'h00; rel_rate_sel = 8'h00;
      mag_in = {16'd0, 16'd0, 16'd60000};
      strobe("R4 R7 first attack beats release");
      // R3: B untouched while A attacks; ch1 now on B with silence
      ch_map = 6'b11_10_01;
      mag_in = {16'd0, 16'd0, 16'd60000};
      strobe("R3 independent");
      // R4: saturate at GR_MAX
      atk_rate_sel = 8'h0F;
      for (int i = 0; i < 20; i++) strobe("R4 clamp");

      // R6: no strobe, inputs move, outputs hold
      mag_in = {16'd1, 16'd2, 16'd3};
      atk_thr_sel = 8'hFF; rel_thr_sel = 8'hFF;
      repeat (4) @(negedge clk);
      check_all("R6 idle hold");

      // R6: between levels -> hold (release level tiny, attack level high)
      rel_thr_sel = 8'h00;
      mag_in = {16'd0, 16'd0, 16'd60000};
      strobe("R6 mid hold R9");

      // R5: silence, wide release level, step 16 down to 0
      rel_thr_sel = 8'hFF; rel_rate_sel = 8'hFF;
      mag_in = '0;
      for (int i = 0; i < 14; i++) strobe("R5 release floor");

      // R8 versus R7: magnitude 100 vs level 4096 (anti-clip) or 16 (vol 0)
      atk_thr_sel = 8'h00; rel_thr_sel = 8'h00; atk_rate_sel = 8'h22;
      vol_lvl = 8'd0;
      mag_in = {16'd0, 16'd0, 16'd100};
      drc_mode = 1'b0;
      strobe("R7 below absolute level");
      drc_mode = 1'b1;
      strobe("R8 above relative level");
      vol_lvl = 8'd255;
      strobe("R8 full volume");

      // random mix
      for (int n = 0; n < 600; n++) begin
         if (($urandom % 16) == 0 || n == 0) begin
            atk_thr_sel  = 8'($urandom);
            rel_thr_sel  = 8'($urandom);
            atk_rate_sel = 8'($urandom);
            rel_rate_sel = 8'($urandom);
            drc_mode     = 1'($urandom);
            vol_lvl      = 8'($urandom);
            ch_map       = 6'($urandom);
         end
         for (int c = 0; c < NCH; c++) begin
            int pick = int'($urandom % 3);
            logic [15:0] mask = (pick == 0) ? 16'hFFFF : (pick == 1) ? 16'h0FFF : 16'h00FF;
            mag_in[c*MW +: MW] = 16'($urandom) & mask;
         end
         if (($urandom % 8) == 0) begin
            repeat (2) @(negedge clk);
            check_all("R6 random idle");
         end
         strobe("R3 R4 R5 R9 random");
      end
      finish_run();
   end
endmodule